// File: doc/BRIEF.md
# Serial DAC Word Receiver

This block is the digital front end of a serially loaded DAC. A host frames each transfer by pulling an active-low frame line low. It then clocks 16 bits onto a data line with a serial clock, most significant bit first. When the frame line returns high, a complete word is committed to a parallel output register. That register stands in for the DAC update.

The upper 4 bits of each word are control bits and the lower 12 bits are DAC data. Two control codes pick which serial clock edge samples data, and the new choice applies from the next frame onwards. A frame that closes before 16 bits have arrived is rejected with a one-cycle error pulse.

All three serial inputs are brought into a faster system clock through two-flop synchronisers, and edges are detected in that domain. The system clock must run at least four times faster than the serial clock.

Top module: `sdr_word_rx`

## Requirements
- R1: After reset the data output is 0, neither pulse output is high, and sampling uses the falling serial-clock edge. A reset in the middle of operation also returns sampling to the falling edge.
- R2: A frame of exactly 16 sampled bits, first bit taken as bit 15, loads word bits [11:0] into `dac_data_o` when the frame line rises, with `update_o` high for exactly one system clock.
- R3: Serial-clock edges that occur while the frame line is high shift nothing and change no output.
- R4: The frame line may stay low through a pause in the serial clock; later edges continue the same word rather than restarting it.
- R5: If the frame line rises after fewer than 16 sampled bits (including zero), `dac_data_o` and the sampling edge are unchanged, `update_o` stays low, and `short_err_o` is high for exactly one system clock.
- R6: Bits after the sixteenth in a frame are ignored. The word is formed from the first 16 bits and is still committed.
- R7: A committed word with bits [15:12] = 4'b1011 selects rising-edge sampling. The change starts with the next frame, and the frame carrying the code is itself sampled on the old edge.
- R8: A committed word with bits [15:12] = 4'b1001 selects falling-edge sampling. Any other code leaves the sampling edge as it was.
- R9: `dac_data_o` changes only in a cycle where `update_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sync_ni | input | 1 | Active-low frame line |
| sdin_i | input | 1 | Serial data, MSB first |
| dac_data_o | output | 12 | Committed DAC data |
| update_o | output | 1 | One-cycle pulse when a word is committed |
| short_err_o | output | 1 | One-cycle pulse when a frame ends short |

## Verification
The hardest situation to reach from the ports is proving which serial-clock edge did the sampling. A correct word comes out under either edge if the data line holds steady for the whole bit.

The stimulus therefore drives the intended bit only in the half-period before the selected edge. In the other half-period it drives the inverted bit as a decoy. With this pattern, a word is decoded correctly only when the edge selection is right.

The same pattern shows that a mode code takes effect on the following frame only. The frame carrying the code is sent with the old edge, and the next frame with the new one.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;

  function automatic edge_sel_e next_edge(input logic [3:0] ctrl,
                                          input logic [3:0] rise_code,
                                          input logic [3:0] fall_code,
                                          input edge_sel_e  cur);
    if (ctrl == rise_code)      next_edge = EDGE_RISE;
    else if (ctrl == fall_code) next_edge = EDGE_FALL;
    else                        next_edge = cur;
  endfunction
endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st[g] <= RST_VAL;
        else         st[g] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st[g] <= RST_VAL;
        else         st[g] <= st[g-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/sdr_edge.sv
module sdr_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lvl_q <= RST_VAL;
    else         lvl_q <= lvl_i;

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/sdr_frame_core.sv
module sdr_frame_core
  import sdr_pkg::*;
#(
  parameter int         WORD_W    = 16,
  parameter int         CTRL_W    = 4,
  parameter logic [3:0] RISE_CODE = 4'b1011,
  parameter logic [3:0] FALL_CODE = 4'b1001,
  localparam int        DATA_W    = WORD_W - CTRL_W,
  localparam int        CNT_W     = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              frame_start_i,
  input  logic              frame_end_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdin_i,
  output logic [DATA_W-1:0] data_o,
  output logic              update_o,
  output logic              short_err_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  edge_sel_e         mode_q;
  logic              sample;
  logic              room;
  logic [3:0]        ctrl;

  assign sample = (mode_q == EDGE_RISE) ? sclk_rise_i : sclk_fall_i;
  assign room   = (cnt_q < FULL);
  assign ctrl   = 4'(shreg_q[WORD_W-1 -: CTRL_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q     <= '0;
      cnt_q       <= '0;
      mode_q      <= EDGE_FALL;
      data_o      <= '0;
      update_o    <= 1'b0;
      short_err_o <= 1'b0;
    end else begin
      update_o    <= 1'b0;
      short_err_o <= 1'b0;
      if (frame_start_i) begin
        cnt_q <= '0;
      end else if (frame_end_i) begin
        cnt_q <= '0;
        if (cnt_q == FULL) begin
          data_o   <= shreg_q[DATA_W-1:0];
          update_o <= 1'b1;
          mode_q   <= next_edge(ctrl, RISE_CODE, FALL_CODE, mode_q);
        end else begin
          short_err_o <= 1'b1;
        end
      end else if (active_i && sample && room) begin
        shreg_q <= {shreg_q[WORD_W-2:0], sdin_i};
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/sdr_word_rx.sv
module sdr_word_rx #(
  parameter int         WORD_W    = 16,
  parameter int         CTRL_W    = 4,
  parameter int         SYNC_ST   = 2,
  parameter logic [3:0] RISE_CODE = 4'b1011,
  parameter logic [3:0] FALL_CODE = 4'b1001,
  localparam int        DATA_W    = WORD_W - CTRL_W,
  localparam int        CNT_W     = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sync_ni,
  input  logic              sdin_i,
  output logic [DATA_W-1:0] dac_data_o,
  output logic              update_o,
  output logic              short_err_o
);
  logic [2:0]       raw, syn;
  logic             sclk_s, sdin_s, sync_s;
  logic             sclk_rise, sclk_fall, sync_rise, sync_fall;
  logic [CNT_W-1:0] bit_cnt;

  assign raw = {sync_ni, sdin_i, sclk_i};
  assign {sync_s, sdin_s, sclk_s} = syn;

  sdr_sync #(.W(3), .STAGES(SYNC_ST), .RST_VAL(3'b100)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  sdr_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sclk_s),
    .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  sdr_edge #(.RST_VAL(1'b1)) u_sync_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sync_s),
    .rise_o(sync_rise), .fall_o(sync_fall)
  );

  sdr_frame_core #(
    .WORD_W(WORD_W), .CTRL_W(CTRL_W),
    .RISE_CODE(RISE_CODE), .FALL_CODE(FALL_CODE)
  ) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .active_i(~sync_s),
    .frame_start_i(sync_fall), .frame_end_i(sync_rise),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .sdin_i(sdin_s),
    .data_o(dac_data_o), .update_o(update_o), .short_err_o(short_err_o),
    .bit_cnt_o(bit_cnt)
  );
endmodule

// File: rtl/sdr_word_rx_chk.sv
module sdr_word_rx_chk #(
  parameter int WORD_W = 16,
  parameter int DATA_W = 12,
  parameter int CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] dac_data_o,
  input logic              update_o,
  input logic              short_err_o,
  input logic [CNT_W-1:0]  bit_cnt
);
  AST_UPD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o); // R2
  AST_UPD_FULL_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> $past(bit_cnt) == CNT_W'(WORD_W)); // R2
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_err_o |=> !short_err_o); // R5
  AST_ERR_NO_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(update_o && short_err_o)); // R5
  AST_ERR_HOLDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_err_o |-> $stable(dac_data_o)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(WORD_W)); // R6
  AST_DATA_ON_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_data_o) |-> update_o); // R9
endmodule

bind sdr_word_rx sdr_word_rx_chk #(
  .WORD_W(WORD_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_sdr_word_rx.sv
module sim_sdr_word_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0;
  logic [11:0] dac_data;
  logic        upd, serr;

  int n_chk = 0, n_bad = 0;
  int upd_cnt = 0, err_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdr_word_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sync_ni(sync_n),
    .sdin_i(sdin), .dac_data_o(dac_data), .update_o(upd), .short_err_o(serr)
  );

  always @(negedge clk) begin
    if (upd)  upd_cnt++;
    if (serr) err_cnt++;
  end

  localparam int NV = 8;
  localparam logic [15:0] VEC_W [NV] = '{16'h0000, 16'h0FFF, 16'h0A5C, 16'h8123,
                                         16'h5FFF, 16'h9001, 16'h7800, 16'h1555};
  localparam logic [11:0] VEC_E [NV] = '{12'h000, 12'hFFF, 12'hA5C, 12'h123,
                                         12'hFFF, 12'h001, 12'h800, 12'h555};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // rise=1: target bit before the rising edge, decoy before the falling one
  task automatic send(input logic [15:0] w, input int nbits, input bit rise,
                      input int pause_at);
    sync_n = 1'b0;
    wclk(6);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < 16) ? w[15-i] : logic'(i % 2);
      sdin = rise ? ~b : b;
      wclk(4);
      sclk = 1'b0;
      wclk(4);
      sdin = rise ? b : ~b;
      wclk(4);
      sclk = 1'b1;
      wclk(4);
      if (i == pause_at) wclk(60);
    end
    wclk(4);
    sync_n = 1'b1;
    wclk(10);
  endtask

  task automatic frame_ok(input string req, input logic [15:0] w, input int nbits,
                          input bit rise, input int pause_at, input logic [11:0] exp);
    int u0c, e0c;
    u0c = upd_cnt;
    e0c = err_cnt;
    send(w, nbits, rise, pause_at);
    check(req, int'(dac_data), int'(exp));
    check(req, upd_cnt - u0c, 1);
    check(req, err_cnt - e0c, 0);
  endtask

  initial begin
    int u0c, e0c;
    logic [11:0] hold;
    wclk(3);
    check("R1", int'(dac_data), 0);
    check("R1", int'(upd), 0);
    check("R1", int'(serr), 0);
    rst_n = 1'b1;
    wclk(5);
    check("R1", upd_cnt + err_cnt, 0);

    // R2 table walk, falling-edge sampling
    for (int k = 0; k < NV; k++)
      frame_ok("R2", VEC_W[k], 16, 1'b0, -1, VEC_E[k]);

    // R3 clock edges outside a frame
    hold = dac_data;
    u0c = upd_cnt; e0c = err_cnt;
    for (int i = 0; i < 10; i++) begin
      sdin = logic'(i % 2); wclk(4); sclk = 1'b0; wclk(4); sclk = 1'b1; wclk(4);
    end
    wclk(10);
    check("R3", int'(dac_data), int'(hold));
    check("R3", upd_cnt - u0c, 0);
    check("R3", err_cnt - e0c, 0);
    frame_ok("R3", 16'h0C35, 16, 1'b0, -1, 12'hC35);

    // R4 pause between two 8-bit bursts
    frame_ok("R4", 16'h0C3A, 16, 1'b0, 7, 12'hC3A);

    // R5 short frames, including one carrying the rising-edge code
    hold = dac_data;
    u0c = upd_cnt; e0c = err_cnt;
    send(16'hB0F0, 12, 1'b0, -1);
    check("R5", int'(dac_data), int'(hold));
    check("R5", upd_cnt - u0c, 0);
    check("R5", err_cnt - e0c, 1);
    send(16'h0000, 0, 1'b0, -1);
    check("R5", err_cnt - e0c, 2);
    check("R5", int'(dac_data), int'(hold));
    frame_ok("R5", 16'h0111, 16, 1'b0, -1, 12'h111);

    // R6 over-length frame
    frame_ok("R6", 16'h07E1, 20, 1'b0, -1, 12'h7E1);

    // R7 rising code applies from the next frame
    frame_ok("R7", 16'hB123, 16, 1'b0, -1, 12'h123);
    frame_ok("R7", 16'h0456, 16, 1'b1, -1, 12'h456);

    // R8 other code keeps rising, falling code returns
    frame_ok("R8", 16'h5789, 16, 1'b1, -1, 12'h789);
    frame_ok("R8", 16'h0ABC, 16, 1'b1, -1, 12'hABC);
    frame_ok("R8", 16'h9DEF, 16, 1'b1, -1, 12'hDEF);
    frame_ok("R8", 16'h0321, 16, 1'b0, -1, 12'h321);

    // R1 mid-run reset restores falling edge and clears output
    frame_ok("R1", 16'hB246, 16, 1'b0, -1, 12'h246);
    rst_n = 1'b0;
    wclk(3);
    check("R1", int'(dac_data), 0);
    rst_n = 1'b1;
    wclk(5);
    frame_ok("R1", 16'h0777, 16, 1'b0, -1, 12'h777);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule